// File: doc/BRIEF.md
# Serial Management Frame Master

This block is the host side of the two-wire management interface that configures and monitors an Ethernet PHY. A request names the direction (read or write), a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then sends one complete management frame on a divided clock and returns the 16-bit value on a read. The serial data line is split into a data output, an output enable and a data input. The tri-state pad sits outside the block.

The management clock runs continuously at the host clock divided by `CLK_DIV`. Every bit the host drives is loaded or shifted on a one-cycle enable that the divider raises in the host cycle just before the management clock falls. The outgoing frame is built from byte-sized chunks that are loaded into an 8-bit shift register:

- the preamble bytes;
- opcode with the high PHY address bits;
- the low PHY address bit with the register address and turnaround;
- the two data bytes.

On reads, the same register collects the incoming bits. It also keeps a link-fail flag that is refreshed whenever PHY register 1 is read.

Top module: `mdio_master`

## Requirements
- R1: During and after reset, with no request made, `busy`, `done`, `mdo`, `mdo_oe`, `link_fail` and `rdata` are all 0.
- R2: `mdc` toggles every `CLK_DIV/2` host cycles, giving a period of `CLK_DIV` cycles with a 50% duty cycle, and runs whether or not a frame is in progress.
- R3: Each frame presents 64 bits, numbered k = 0..63 in transmit order, each on one `mdc` low-to-high edge. Bits 0..31 are a preamble of ones, and bits 32 and 33 are the start pattern 0 then 1.
- R4: Bits 34 and 35 are the opcode: 1,0 for a read (`req_write`=0) and 0,1 for a write. Bits 36..40 carry `req_phy` and bits 41..45 carry `req_reg`, each most significant bit first.
- R5: On a write, bits 46 and 47 are the turnaround 1 then 0, bits 48..63 carry `req_wdata` most significant bit first, and `mdo_oe` is 1 for all 64 bits.
- R6: On a read, `mdo_oe` is 1 for bits 0..45 and 0 for bits 46..63. For k = 48..63, `mdi` is sampled on the rising `mdc` edge of bit k, and that bit lands in `rdata[63-k]`. A write leaves `rdata` unchanged.
- R7: `mdo` changes only in the host cycle in which `mdc` falls.
- R8: A request with `busy`=0 starts a frame and raises `busy`. `done` is a one-cycle pulse, raised at the falling `mdc` edge after bit 63, in the same cycle `busy` drops. A request made while `busy`=1 is ignored.
- R9: When a read of register address 1 completes, `link_fail` becomes the inverse of bit 2 of the value read. Other reads and all writes leave `link_fail` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a transaction (taken only when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address inside the PHY |
| req_wdata | input | 16 | Value to write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdata | output | 16 | Last value read |
| link_fail | output | 1 | Link-fail status flag |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data out |
| mdo_oe | output | 1 | Output enable for the data pad |
| mdi | input | 1 | Serial data in |

## Verification
A PHY model in the bench records `mdo` and `mdo_oe` on every rising `mdc` edge. For reads, it answers with a chosen word. A write with mixed address and data bits shows that opcode, address, turnaround and data land in the right positions. Reads of words with alternating nibbles, run next to that write, show that the enable is released at the turnaround and that the byte halves come back in the right order. Reads of register 1 with bit 2 clear and set, against reads of another register and a write to register 1, separate a link-fail update from no update. A request injected mid-frame shows that the frame, the read value and the single done pulse are untouched.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
    localparam int          BYTE_W    = 8;
    localparam int          DATA_W    = 16;
    localparam int          ADDR_W    = 5;
    localparam logic [1:0]  START_PAT = 2'b01;
    localparam logic [1:0]  OP_READ   = 2'b10;
    localparam logic [1:0]  OP_WRITE  = 2'b01;
    localparam logic [1:0]  TURN_WR   = 2'b10;
    localparam logic [4:0]  STATUS_REG = 5'd1;
    localparam int          LINK_BIT  = 2;

    // byte chunk number idx (0..3) of the part of the frame after the preamble
    function automatic logic [BYTE_W-1:0] frame_chunk(
        input logic [1:0]        idx,
        input logic              wr,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regad,
        input logic [DATA_W-1:0] wdata
    );
        logic [1:0] op;
        op = wr ? OP_WRITE : OP_READ;
        case (idx)
            2'd0:    frame_chunk = {START_PAT, op, phy[4:1]};
            2'd1:    frame_chunk = {phy[0], regad, TURN_WR};
            2'd2:    frame_chunk = wdata[15:8];
            default: frame_chunk = wdata[7:0];
        endcase
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic fall_en,
    output logic rise_en
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } clk_st_t;

    clk_st_t s_d, s_q;
    logic    wrap;

    assign wrap = (s_q.cnt == CW'(HALF - 1));

    always_comb begin
        s_d = s_q;
        if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc     = s_q.mdc;
    assign fall_en = wrap &  s_q.mdc;
    assign rise_en = wrap & ~s_q.mdc;
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_en,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              oe,
    output logic              step,
    output logic              load,
    output logic [BYTE_W-1:0] chunk,
    output logic              latch_hi,
    output logic              latch_lo,
    output logic              link_upd
);
    localparam int FRAME    = PRE_LEN + 32;
    localparam int PW       = $clog2(FRAME + 1);
    localparam int TA_POS   = PRE_LEN + 14;
    localparam int DATA_POS = PRE_LEN + 16;
    localparam int MID_POS  = PRE_LEN + 24;

    typedef struct packed {
        logic              busy;
        logic              wr;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
        logic [PW-1:0]     pos;
        logic              oe;
        logic              done;
    } seq_st_t;

    seq_st_t s_d, s_q;
    logic    at_end, in_pre, rd_data;

    always_comb begin
        at_end  = (s_q.pos == PW'(FRAME));
        in_pre  = (s_q.pos < PW'(PRE_LEN));
        rd_data = !s_q.wr && (s_q.pos >= PW'(DATA_POS));
        step    = fall_en && s_q.busy;
        load    = step && (s_q.pos[2:0] == 3'd0) && !at_end && !rd_data;
        chunk   = in_pre ? {BYTE_W{1'b1}}
                         : frame_chunk(2'((s_q.pos - PW'(PRE_LEN)) >> 3),
                                       s_q.wr, s_q.phy, s_q.regad, s_q.wdata);
        latch_hi = step && !s_q.wr && (s_q.pos == PW'(MID_POS));
        latch_lo = step && !s_q.wr && at_end;
        link_upd = latch_lo && (s_q.regad == STATUS_REG);

        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (req) begin
                s_d.busy  = 1'b1;
                s_d.wr    = req_write;
                s_d.phy   = req_phy;
                s_d.regad = req_reg;
                s_d.wdata = req_wdata;
                s_d.pos   = '0;
            end
        end else if (step) begin
            if (at_end) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.oe   = 1'b0;
            end else begin
                s_d.pos = s_q.pos + 1'b1;
                s_d.oe  = !(!s_q.wr && (s_q.pos >= PW'(TA_POS)));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign oe   = s_q.oe;
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              rise_en,
    input  logic              load,
    input  logic [BYTE_W-1:0] chunk,
    input  logic              latch_hi,
    input  logic              latch_lo,
    input  logic              link_upd,
    input  logic              mdi,
    output logic              mdo,
    output logic [DATA_W-1:0] rdata,
    output logic              link_fail
);
    typedef struct packed {
        logic [BYTE_W-1:0] sr;
        logic              samp;
        logic [DATA_W-1:0] rdata;
        logic              link;
    } sh_st_t;

    sh_st_t            s_d, s_q;
    logic [BYTE_W-1:0] shifted;

    always_comb begin
        shifted = {s_q.sr[BYTE_W-2:0], s_q.samp};
        s_d     = s_q;
        if (rise_en) s_d.samp = mdi;
        if (step)    s_d.sr   = load ? chunk : shifted;
        if (latch_hi) s_d.rdata[DATA_W-1:BYTE_W] = shifted;
        if (latch_lo) s_d.rdata[BYTE_W-1:0]      = shifted;
        if (link_upd) s_d.link = ~shifted[LINK_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdo       = s_q.sr[BYTE_W-1];
    assign rdata     = s_q.rdata;
    assign link_fail = s_q.link;
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              link_fail,
    output logic              mdc,
    output logic              mdo,
    output logic              mdo_oe,
    input  logic              mdi
);
    logic              fall_en, rise_en, step, load, latch_hi, latch_lo, link_upd;
    logic [BYTE_W-1:0] chunk;

    mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .fall_en (fall_en),
        .rise_en (rise_en)
    );

    mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_en   (fall_en),
        .req       (req),
        .req_write (req_write),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .busy      (busy),
        .done      (done),
        .oe        (mdo_oe),
        .step      (step),
        .load      (load),
        .chunk     (chunk),
        .latch_hi  (latch_hi),
        .latch_lo  (latch_lo),
        .link_upd  (link_upd)
    );

    mdio_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .rise_en   (rise_en),
        .load      (load),
        .chunk     (chunk),
        .latch_hi  (latch_hi),
        .latch_lo  (latch_lo),
        .link_upd  (link_upd),
        .mdi       (mdi),
        .mdo       (mdo),
        .rdata     (rdata),
        .link_fail (link_fail)
    );
endmodule

// File: rtl/mdio_master_sva.sv
`timescale 1ns/1ps
module mdio_master_sva #(
    parameter int CLK_DIV = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdo,
    input logic        mdo_oe,
    input logic        busy,
    input logic        done,
    input logic [15:0] rdata,
    input logic        link_fail
);
    localparam int HALF = CLK_DIV / 2;

    logic        mdc_prev_q, seen_q;
    logic [15:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_prev_q <= 1'b0;
            seen_q     <= 1'b0;
            gap_q      <= 16'd1;
        end else begin
            mdc_prev_q <= mdc;
            if (mdc != mdc_prev_q) begin
                gap_q  <= 16'd1;
                seen_q <= 1'b1;
            end else begin
                gap_q  <= gap_q + 16'd1;
            end
        end
    end

    a_r2_mdc_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (mdc != mdc_prev_q)) |-> (gap_q == 16'(HALF)));

    a_r7_mdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdo) |-> $fell(mdc));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    a_r6_oe_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mdo_oe |-> busy);

    a_r6_rdata_moves_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> (busy || done));

    a_r9_link_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_fail) |-> done);
endmodule

bind mdio_master mdio_master_sva #(.CLK_DIV(CLK_DIV)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdo       (mdo),
    .mdo_oe    (mdo_oe),
    .busy      (busy),
    .done      (done),
    .rdata     (rdata),
    .link_fail (link_fail)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
    localparam int DIV = 4;
    localparam logic [63:0] PRE_M  = 64'hFFFF_FFFF_C000_0000;
    localparam logic [63:0] ADDR_M = 64'h0000_0000_3FFC_0000;
    localparam logic [63:0] DATA_M = 64'h0000_0000_0003_FFFF;
    localparam logic [63:0] OE_RD  = 64'hFFFF_FFFF_FFFC_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_write = 1'b0;
    logic [4:0]  req_phy = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, link_fail, mdc, mdo, mdo_oe;
    logic [15:0] rdata;
    logic        mdi;

    int checks = 0;
    int errors = 0;

    // PHY model state
    logic        mon_prev_mdc = 1'b0, mon_prev_busy = 1'b0;
    int          nf = 0, nrise = 0, ndone = 0;
    logic [63:0] got_mdo = '0, got_oe = '0;
    logic [15:0] phy_word = '0;

    always #4 clk = ~clk;

    mdio_master uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .link_fail(link_fail),
        .mdc(mdc), .mdo(mdo), .mdo_oe(mdo_oe), .mdi(mdi)
    );

    always @(negedge clk) begin
        if (mdc && !mon_prev_mdc && busy && nf > 0 && nf <= 64) begin
            got_mdo[64 - nf] = mdo;
            got_oe[64 - nf]  = mdo_oe;
            nrise++;
        end
        if (!mdc && mon_prev_mdc && mon_prev_busy) begin
            nf++;
            if (nf - 1 >= 48 && nf - 1 <= 63) mdi = phy_word[63 - (nf - 1)];
            else                              mdi = 1'b1;
        end
        if (nf == 0) mdi = 1'b1;
        if (done) ndone++;
        mon_prev_mdc  = mdc;
        mon_prev_busy = busy;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] wd, input logic [15:0] pw, input bit spam);
        logic [63:0] exp_f, exp_oe;
        int          wait_n;
        phy_word = pw;
        nf = 0; nrise = 0; ndone = 0; got_mdo = '0; got_oe = '0;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        if (spam) begin
            repeat (100) @(negedge clk);
            req = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
            @(negedge clk);
            req = 1'b0;
        end
        wait_n = 0;
        while (ndone == 0 && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(ndone != 0, "R8 frame completes", wait_n, 0);
        repeat (3) @(negedge clk);
        exp_f  = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg, 2'b10, (wr ? wd : pw)};
        exp_oe = wr ? 64'hFFFF_FFFF_FFFF_FFFF : OE_RD;
        chk(((got_mdo ^ exp_f) & PRE_M) == 0, "R3 preamble/start", got_mdo & PRE_M, exp_f & PRE_M);
        chk(((got_mdo ^ exp_f) & ADDR_M) == 0, "R4 opcode/addresses", got_mdo & ADDR_M, exp_f & ADDR_M);
        if (wr) begin
            chk(((got_mdo ^ exp_f) & DATA_M) == 0, "R5 turnaround/data", got_mdo & DATA_M, exp_f & DATA_M);
            chk(got_oe == exp_oe, "R5 output enable", got_oe, exp_oe);
        end else begin
            chk(got_oe == exp_oe, "R6 output enable", got_oe, exp_oe);
        end
        chk(nrise == 64, "R3 bit count", nrise, 64);
        chk(ndone == 1, "R8 single done", ndone, 1);
        chk(busy == 1'b0, "R8 busy after done", busy, 0);
    endtask

    task automatic test_reset();
        chk(busy == 0 && done == 0 && mdo_oe == 0 && mdo == 0, "R1 control outputs",
            {busy, done, mdo_oe, mdo}, 0);
        chk(rdata == 16'h0 && link_fail == 0, "R1 rdata/link", {rdata, link_fail}, 0);
    endtask

    task automatic test_clock();
        for (int p = 0; p < 3; p++) begin
            int n, h;
            logic prev;
            prev = mdc;
            while (!(mdc && !prev)) begin prev = mdc; @(negedge clk); end
            n = 0; h = 0;
            do begin
                if (mdc) h++;
                n++;
                prev = mdc;
                @(negedge clk);
            end while (!(mdc && !prev));
            chk(n == DIV && h == DIV / 2, "R2 mdc period/duty", {n, h}, {DIV, DIV / 2});
        end
    endtask

    task automatic test_write();
        run_txn(1'b1, 5'h15, 5'h0A, 16'hA53C, 16'h0000, 1'b0);
        chk(rdata == 16'h0000, "R6 write leaves rdata", rdata, 16'h0000);
    endtask

    task automatic test_read();
        run_txn(1'b0, 5'h0A, 5'h13, 16'h0000, 16'h5AC3, 1'b0);
        chk(rdata == 16'h5AC3, "R6 read value", rdata, 16'h5AC3);
        chk(link_fail == 1'b0, "R9 other register ignored", link_fail, 0);
        run_txn(1'b0, 5'h1F, 5'h00, 16'h0000, 16'hC35A, 1'b0);
        chk(rdata == 16'hC35A, "R6 read value 2", rdata, 16'hC35A);
    endtask

    task automatic test_link();
        run_txn(1'b0, 5'h01, 5'h01, 16'h0000, 16'h7FFB, 1'b0);
        chk(link_fail == 1'b1, "R9 link set on bit2=0", link_fail, 1);
        run_txn(1'b1, 5'h01, 5'h01, 16'h0004, 16'h0000, 1'b0);
        chk(link_fail == 1'b1, "R9 write ignored", link_fail, 1);
        run_txn(1'b0, 5'h01, 5'h02, 16'h0000, 16'h0004, 1'b0);
        chk(link_fail == 1'b1, "R9 register 2 ignored", link_fail, 1);
        run_txn(1'b0, 5'h01, 5'h01, 16'h0000, 16'h0004, 1'b0);
        chk(link_fail == 1'b0, "R9 link clear on bit2=1", link_fail, 0);
    endtask

    task automatic test_busy_ignore();
        run_txn(1'b0, 5'h0C, 5'h05, 16'h0000, 16'h9E61, 1'b1);
        chk(rdata == 16'h9E61, "R8 request while busy ignored", rdata, 16'h9E61);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R8 no queued frame", busy, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_clock();
        test_write();
        test_read();
        test_link();
        test_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R8 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule